// File: doc/BRIEF.md
# Multi-Mode Prescaled Down Timer

This block is an 8-bit down-counting timer driven by an 8-bit prescaler. Both stages are reloadable. A count tick first steps the prescaler. Each time the prescaler wraps, the timer steps once. When the timer wraps, it reloads from its latch, sets an interrupt request flag and, in pulse output mode, flips the pulse pin. The overall period is therefore (n+1)(m+1) source ticks, where n is the prescaler latch value and m is the timer latch value.

A mode byte selects where the count ticks come from:
- the system clock, either undivided or divided by four;
- active edges on an external count pin;
- the system clock, gated by the pin being at its active level, which measures pulse width.

The count pin is resynchronised and edge-detected inside the block. Software reaches the latches, the live counter values, the mode byte and the flag acknowledge through a small address/data port. Reads are combinational. Writes take effect on the clock edge that samples them.

Top module: `modal_timer`

## Requirements
- R1: After reset, both counters read 0xFF, the mode byte reads 0x80 (halted, timer mode, rising edge, undivided source), `irq` is 0 and `pulse_out` is 0.
- R2: Register map (address 2 bits): 0 = prescaler, 1 = timer, 2 = mode byte, 3 = flag. Writing address 0 or 1 loads both the latch and the live counter, and a read of that address returns the new counter value after the write edge. Address 3 reads `{7'b0, irq}`.
- R3: In timer mode with the undivided source, the first underflow after the mode write comes (n+1)(m+1) clocks later. Successive underflows are spaced by the same number of clocks.
- R4: A timer underflow sets `irq` to 1. Writing address 3 with bit 0 = 1 clears it. Writing address 3 with bit 0 = 0 leaves it set.
- R5: When a counter is at 0 and receives a tick, it reloads from its latch. A timer value of 0 thus lasts exactly one timer period, not a wrap to 255.
- R6: Mode bit 7 = 1 halts counting. Both counters hold their values while it is set.
- R7: In pulse output mode (mode bits [1:0] = 01), `pulse_out` inverts at every timer underflow. In every other mode it holds its value.
- R8: In event mode (bits [1:0] = 10), each active edge of `cnt_pin` is one tick. Bit 2 = 0 selects rising edges and bit 2 = 1 selects falling edges. The counter changes on the third clock edge after the pin changes.
- R9: In width mode (bits [1:0] = 11), the clock ticks only while the synchronised pin is high (bit 2 = 0) or low (bit 2 = 1). A pulse held for H clocks produces exactly H ticks.
- R10: Mode bit 3 = 1 selects one source tick per four clocks, which makes the underflow spacing 4(n+1)(m+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin | input | 1 | External count / gate pin, asynchronous |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pulse_out | output | 1 | Toggling pulse output |
| irq | output | 1 | Timer underflow request flag |

## Verification
- **Register effects.** A register write shows in the read data one clock after the write edge. The bench drives each write on a falling edge and reads on the next falling edge.
- **Pin latency.** A pin change reaches the counters on the third rising edge: two edges for the synchroniser, then the counter edge. The event latency check samples the counter after the second falling edge and again after the third.
- **Period checks.** Underflow timing is measured by counting falling edges between successive `pulse_out` changes, or from the mode write to `irq`. Any fixed offset therefore drops out, and the expected count is (n+1)(m+1), times four with the divided source.
- **Width mode.** The gate window is shifted by the same two-clock synchroniser delay at both ends, so the bench expects exactly H ticks.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;

    localparam logic [1:0] ADR_PRE  = 2'd0;
    localparam logic [1:0] ADR_TMR  = 2'd1;
    localparam logic [1:0] ADR_CFG  = 2'd2;
    localparam logic [1:0] ADR_FLAG = 2'd3;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_WIDTH = 2'b11
    } tmode_e;

    typedef struct packed {
        logic       halt;
        logic [2:0] spare;
        logic       slow_src;
        logic       fall_sel;
        tmode_e     mode;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{halt: 1'b1, spare: 3'b000,
                                        slow_src: 1'b0, fall_sel: 1'b0,
                                        mode: MODE_TIMER};

    // Unused bits are forced to zero so reads return a clean byte.
    function automatic mode_cfg_t to_cfg(input logic [DATA_W-1:0] raw);
        mode_cfg_t c;
        c          = mode_cfg_t'(raw);
        c.spare    = 3'b000;
        return c;
    endfunction

endpackage

// File: rtl/mt_pin_sync.sv
module mt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic level_active,
    output logic edge_hit
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              lvl;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign lvl = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign level_active = lvl ^ fall_sel;
    assign edge_hit     = fall_sel ? (prev & ~lvl) : (lvl & ~prev);
endmodule

// File: rtl/mt_src_div.sv
module mt_src_div #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic base_tick
);
    generate
        if (DIV_LOG2 == 0) begin : g_nodiv
            assign base_tick = 1'b1;
        end else begin : g_div
            logic [DIV_LOG2-1:0] div_cnt;
            always_ff @(posedge clk) begin
                if (rst) div_cnt <= '0;
                else     div_cnt <= div_cnt + 1'b1;
            end
            assign base_tick = slow_sel ? (&div_cnt) : 1'b1;
        end
    endgenerate
endmodule

// File: rtl/mt_down_counter.sv
module mt_down_counter #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    assign wrap = tick && (value == '0);

    always_ff @(posedge clk) begin
        if (rst)       value <= RST_VAL;
        else if (load) value <= load_val;
        else if (wrap) value <= reload_val;
        else if (tick) value <= value - 1'b1;
    end
endmodule

// File: rtl/mt_regs.sv
module mt_regs
    import modal_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  pre_latch,
    output logic [CNT_W-1:0]  tmr_latch,
    output mode_cfg_t         cfg,
    output logic              pre_load,
    output logic              tmr_load,
    output logic              flag_clr
);
    assign pre_load = bus_wr && (bus_addr == ADR_PRE);
    assign tmr_load = bus_wr && (bus_addr == ADR_TMR);
    assign flag_clr = bus_wr && (bus_addr == ADR_FLAG) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_latch <= '1;
            tmr_latch <= '1;
            cfg       <= CFG_RESET;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADR_PRE: pre_latch <= bus_wdata[CNT_W-1:0];
                ADR_TMR: tmr_latch <= bus_wdata[CNT_W-1:0];
                ADR_CFG: cfg       <= to_cfg(bus_wdata);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/modal_timer.sv
module modal_timer
    import modal_timer_pkg::*;
#(
    parameter int DIV_LOG2    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_pin,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pulse_out,
    output logic              irq
);
    logic [CNT_W-1:0] pre_latch, tmr_latch, pre_value, tmr_value;
    mode_cfg_t        cfg;
    logic             pre_load, tmr_load, flag_clr;
    logic             level_active, edge_hit, base_tick;
    logic             src_tick, pre_tick, pre_wrap, tmr_wrap;

    mt_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pre_latch(pre_latch), .tmr_latch(tmr_latch),
        .cfg(cfg), .pre_load(pre_load), .tmr_load(tmr_load), .flag_clr(flag_clr)
    );

    mt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .fall_sel(cfg.fall_sel),
        .level_active(level_active), .edge_hit(edge_hit)
    );

    mt_src_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst(rst), .slow_sel(cfg.slow_src), .base_tick(base_tick)
    );

    always_comb begin
        unique case (cfg.mode)
            MODE_EVENT: src_tick = edge_hit;
            MODE_WIDTH: src_tick = base_tick & level_active;
            default:    src_tick = base_tick;
        endcase
        pre_tick = src_tick & ~cfg.halt;
    end

    mt_down_counter #(.W(CNT_W)) u_pre (
        .clk(clk), .rst(rst), .load(pre_load), .load_val(bus_wdata[CNT_W-1:0]),
        .tick(pre_tick), .reload_val(pre_latch), .value(pre_value), .wrap(pre_wrap)
    );

    mt_down_counter #(.W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(bus_wdata[CNT_W-1:0]),
        .tick(pre_wrap), .reload_val(tmr_latch), .value(tmr_value), .wrap(tmr_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            pulse_out <= 1'b0;
        end else begin
            if (tmr_wrap)      irq <= 1'b1;
            else if (flag_clr) irq <= 1'b0;
            if (tmr_wrap && cfg.mode == MODE_PULSE) pulse_out <= ~pulse_out;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_PRE:  bus_rdata = DATA_W'(pre_value);
            ADR_TMR:  bus_rdata = DATA_W'(tmr_value);
            ADR_CFG:  bus_rdata = cfg;
            default:  bus_rdata = {{(DATA_W-1){1'b0}}, irq};
        endcase
    end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
    import modal_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             clr_bit,
    input logic             halt,
    input logic [1:0]       mode,
    input logic             level_active,
    input logic [CNT_W-1:0] pre_value,
    input logic [CNT_W-1:0] tmr_value,
    input logic             pre_wrap,
    input logic             tmr_wrap,
    input logic             irq,
    input logic             pulse_out
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halt && !bus_wr) |=> ($stable(pre_value) && $stable(tmr_value))); // R6

    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        tmr_wrap |=> irq); // R4

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_FLAG && clr_bit && !tmr_wrap) |=> !irq); // R4

    AST_PULSE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (tmr_wrap && mode == MODE_PULSE) |=> (pulse_out != $past(pulse_out))); // R7

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(tmr_wrap && mode == MODE_PULSE) |=> $stable(pulse_out)); // R7

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && pre_wrap && tmr_value != '0)
            |=> (tmr_value == CNT_W'($past(tmr_value) - 1'b1))); // R3

    AST_WIDTH_GATE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDTH && !level_active && !bus_wr) |=> $stable(pre_value)); // R9
endmodule

bind modal_timer mt_checker u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .clr_bit(bus_wdata[0]), .halt(cfg.halt), .mode(cfg.mode),
    .level_active(level_active), .pre_value(pre_value), .tmr_value(tmr_value),
    .pre_wrap(pre_wrap), .tmr_wrap(tmr_wrap), .irq(irq), .pulse_out(pulse_out)
);

// File: tb/tb_modal_timer.sv
module tb_modal_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_pin;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       pulse_out;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    modal_timer dut (
        .clk(clk), .rst(rst), .cnt_pin(cnt_pin), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pulse_out(pulse_out), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int exp_period(input int p, input int t, input bit slow);
        return (p + 1) * (t + 1) * (slow ? 4 : 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(input int p, input int t);
        wr(2'd2, 8'h80);
        wr(2'd0, 8'(p));
        wr(2'd1, 8'(t));
        wr(2'd3, 8'h01);
    endtask

    task automatic measure_toggle(output int n);
        logic s;
        int g;
        s = pulse_out; g = 0;
        while (pulse_out == s && g < 5000) begin @(negedge clk); g++; end
        s = pulse_out; n = 0;
        while (pulse_out == s && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int v, p, t, k, h, a, b;
        v = $urandom(32'd2024);
        rst = 1'b1; cnt_pin = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state, R2 register map
        rd(2'd0, v); chk("R1 prescaler reset", v, 255);
        rd(2'd1, v); chk("R1 timer reset", v, 255);
        rd(2'd2, v); chk("R1 mode reset", v, 8'h80);
        rd(2'd3, v); chk("R1 irq reset", v, 0);
        chk("R1 pulse reset", int'(pulse_out), 0);

        // R2 latch write loads counter; R6 halted holds
        wr(2'd0, 8'd3); wr(2'd1, 8'd5);
        rd(2'd0, v); chk("R2 prescaler load", v, 3);
        rd(2'd1, v); chk("R2 timer load", v, 5);
        idle(20);
        rd(2'd1, v); chk("R6 halted timer holds", v, 5);
        rd(2'd0, v); chk("R6 halted prescaler holds", v, 3);

        // R3 first underflow timing, corner cases plus random
        for (int i = 0; i < 6; i++) begin
            p = (i == 0) ? 0 : (i == 1) ? 7 : int'($urandom_range(0, 7));
            t = (i == 0) ? 0 : (i == 1) ? 0 : int'($urandom_range(0, 7));
            setup(p, t);
            wr(2'd2, 8'h00);
            k = 0;
            while (!irq && k < 5000) begin @(negedge clk); k++; end
            chk("R3 first underflow", k, exp_period(p, t, 0));
        end

        // R4 flag clear
        wr(2'd2, 8'h80);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R4 write bit0=0 keeps irq", v, 1);
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R4 write bit0=1 clears irq", v, 0);

        // R7 pulse holds in timer mode
        setup(0, 2);
        wr(2'd2, 8'h00);
        b = int'(pulse_out);
        idle(40);
        chk("R7 pulse holds outside pulse mode", int'(pulse_out), b);
        chk("R4 irq set by underflow", int'(irq), 1);

        // R7/R3/R5 pulse spacing, including timer latch 0
        for (int i = 0; i < 5; i++) begin
            p = int'($urandom_range(0, 6));
            t = (i == 0) ? 0 : int'($urandom_range(0, 6));
            setup(p, t);
            wr(2'd2, 8'h01);
            measure_toggle(k);
            chk("R7 R5 pulse spacing", k, exp_period(p, t, 0));
        end

        // R6 halt mid-run
        setup(3, 200);
        wr(2'd2, 8'h00);
        idle(30);
        wr(2'd2, 8'h80);
        rd(2'd1, a);
        idle(25);
        rd(2'd1, b);
        chk("R6 halt mid-run", b, a);

        // R10 divided source
        for (int i = 0; i < 3; i++) begin
            p = int'($urandom_range(0, 4));
            t = int'($urandom_range(0, 4));
            setup(p, t);
            wr(2'd2, 8'h09);
            measure_toggle(k);
            chk("R10 slow source spacing", k, exp_period(p, t, 1));
        end

        // R8 event latency, rising edges
        setup(0, 100);
        wr(2'd2, 8'h02);
        idle(3);
        cnt_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(2'd1, v); chk("R8 no count before third edge", v, 100);
        @(negedge clk);
        rd(2'd1, v); chk("R8 count on third edge", v, 99);
        idle(3); cnt_pin = 1'b0; idle(3);
        k = int'($urandom_range(3, 20));
        for (int i = 0; i < k; i++) begin
            cnt_pin = 1'b1; idle(3); cnt_pin = 1'b0; idle(3);
        end
        idle(4);
        rd(2'd1, v); chk("R8 rising edge count", v, 99 - k);

        // R8 falling edges
        setup(0, 100);
        wr(2'd2, 8'h06);
        k = int'($urandom_range(3, 20));
        for (int i = 0; i < k; i++) begin
            cnt_pin = 1'b1; idle(3); cnt_pin = 1'b0; idle(3);
        end
        idle(4);
        rd(2'd1, v); chk("R8 falling edge count", v, 100 - k);

        // R9 width, high active, idle level ignored
        setup(0, 200);
        wr(2'd2, 8'h03);
        idle(20);
        rd(2'd1, v); chk("R9 inactive level no count", v, 200);
        h = int'($urandom_range(1, 60));
        cnt_pin = 1'b1; idle(h); cnt_pin = 1'b0;
        idle(6);
        rd(2'd1, v); chk("R9 high width", v, 200 - h);

        // R9 width, low active
        cnt_pin = 1'b1;
        setup(0, 200);
        idle(4);
        wr(2'd2, 8'h07);
        h = int'($urandom_range(1, 60));
        cnt_pin = 1'b0; idle(h); cnt_pin = 1'b1;
        idle(6);
        rd(2'd1, v); chk("R9 low width", v, 200 - h);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule